// File: doc/BRIEF.md
# Segment Translation and Protection Unit

The unit turns a logical address into a physical one. The logical address is a segment number plus an offset. A small segment table sits in internal registers and software loads it through a write port. Each entry has a base address, a length (limit), a valid flag and three permission flags: read, write and execute. A length register sets how many segments are in use.

Every request carries an access type. One clock edge later, the unit returns either the translated physical address or a fault code. Four checks run side by side: segment number against the length register, entry validity, offset against limit, and access type against the permission flags. A fixed priority picks the single code that is reported.

The table and the length register change only on a clock edge. A request in the same cycle as an update therefore sees the contents from before that update.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the length register is 0 and every table entry is invalid. While reset holds, and until the first request, rsp_valid_o, fault_strobe_o, fault_o and pa_o are all 0.
- R2: A request whose segment number is greater than or equal to the length register returns fault code 1 (range).
- R3: A request to an in-range entry whose valid flag is 0 returns fault code 2 (invalid).
- R4: A request whose offset is greater than or equal to the entry limit returns fault code 3 (limit).
- R5: Permission bit 0 allows read (access code 0), bit 1 allows write (access code 1) and bit 2 allows execute (access code 2). Access code 3 is always denied. A denied access returns fault code 4 (permission).
- R6: When several faults apply, the reported code follows this priority: range, then invalid, then limit, then permission.
- R7: A request accepted on a clock edge gives rsp_valid_o = 1 from that edge on. With no fault, fault_o is 0 and pa_o is base plus offset, taken modulo 2^PA_W.
- R8: On any fault, pa_o is 0 and fault_strobe_o is 1. With no fault, fault_strobe_o is 0.
- R9: A length write takes effect from the next cycle. A request in the same cycle as the write is checked against the old length.
- R10: A length value written above NUM_SEG is stored as NUM_SEG.
- R11: A table write takes effect from the next cycle. A request to the same entry in the same cycle uses the old entry.
- R12: A cycle with no request gives rsp_valid_o, fault_strobe_o, fault_o and pa_o all 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| seg_i | input | SNUM_W | Segment number |
| off_i | input | OFF_W | Offset within segment |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_we_i | input | 1 | Table entry write enable |
| tbl_idx_i | input | IDX_W | Entry index to write |
| tbl_base_i | input | PA_W | Base address for the entry |
| tbl_limit_i | input | OFF_W+1 | Segment length for the entry |
| tbl_valid_i | input | 1 | Valid flag for the entry |
| tbl_perm_i | input | 3 | Permission flags {exec, write, read} |
| len_we_i | input | 1 | Length register write enable |
| len_i | input | LEN_W | New segment count |
| rsp_valid_o | output | 1 | Response valid |
| pa_o | output | PA_W | Physical address, 0 on fault |
| fault_o | output | 3 | Fault code: 0 none, 1 range, 2 invalid, 3 limit, 4 permission |
| fault_strobe_o | output | 1 | High on a faulting response |

## Verification
Two kinds of event can land in the same cycle: a translation request and a write to the length register or to the entry that the request selects. The bench provokes this by raising the length write enable, or the table write enable, in the very cycle it issues the request. The response must reflect the old length or the old entry. A repeat of the same request on the next cycle must reflect the new value, and the two results are chosen so that their fault codes differ.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } flt_e;

  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned PA_W    = 16,
  parameter int unsigned LIM_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [PA_W-1:0]  wbase_i,
  input  logic [LIM_W-1:0] wlimit_i,
  input  logic             wvalid_i,
  input  logic [2:0]       wperm_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [PA_W-1:0]  rbase_o,
  output logic [LIM_W-1:0] rlimit_o,
  output logic             rvalid_o,
  output logic [2:0]       rperm_o
);
  logic [PA_W-1:0]  base_q  [NUM_SEG];
  logic [LIM_W-1:0] limit_q [NUM_SEG];
  logic             vld_q   [NUM_SEG];
  logic [2:0]       perm_q  [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (widx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        vld_q[g]   <= 1'b0;
        perm_q[g]  <= '0;
      end else if (hit) begin
        base_q[g]  <= wbase_i;
        limit_q[g] <= wlimit_i;
        vld_q[g]   <= wvalid_i;
        perm_q[g]  <= wperm_i;
      end
    end
  end

  // indices at or above NUM_SEG read as an empty entry
  always_comb begin
    rbase_o  = '0;
    rlimit_o = '0;
    rvalid_o = 1'b0;
    rperm_o  = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (ridx_i == IDX_W'(i)) begin
        rbase_o  = base_q[i];
        rlimit_o = limit_q[i];
        rvalid_o = vld_q[i];
        rperm_o  = perm_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SNUM_W = 4,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 16
) (
  input  logic [SNUM_W-1:0] seg_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  input  logic [PA_W-1:0]   base_i,
  input  logic [OFF_W:0]    limit_i,
  input  logic              valid_i,
  input  logic [2:0]        perm_i,
  output flt_e              flt_o,
  output logic [PA_W-1:0]   pa_o
);
  localparam int unsigned CMP_W = (SNUM_W > LEN_W) ? SNUM_W : LEN_W;

  logic [CMP_W-1:0] seg_x, len_x;
  logic             out_rng, over_lim, allowed;

  assign seg_x    = CMP_W'(seg_i);
  assign len_x    = CMP_W'(len_i);
  assign out_rng  = seg_x >= len_x;
  assign over_lim = {1'b0, off_i} >= limit_i;

  always_comb begin
    case (acc_i)
      ACC_READ:  allowed = perm_i[PERM_R];
      ACC_WRITE: allowed = perm_i[PERM_W];
      ACC_EXEC:  allowed = perm_i[PERM_X];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (out_rng)       flt_o = FLT_RANGE;
    else if (!valid_i) flt_o = FLT_INVALID;
    else if (over_lim) flt_o = FLT_LIMIT;
    else if (!allowed) flt_o = FLT_PERM;
    else               flt_o = FLT_NONE;
  end

  assign pa_o = base_i + PA_W'(off_i);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 16,
  localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned SNUM_W = IDX_W + 1,
  localparam int unsigned LEN_W  = $clog2(NUM_SEG + 1),
  localparam int unsigned LIM_W  = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SNUM_W-1:0] seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [PA_W-1:0]   tbl_base_i,
  input  logic [LIM_W-1:0]  tbl_limit_i,
  input  logic              tbl_valid_i,
  input  logic [2:0]        tbl_perm_i,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [2:0]        fault_o,
  output logic              fault_strobe_o
);
  logic [LEN_W-1:0] len_q;
  logic [PA_W-1:0]  ent_base;
  logic [LIM_W-1:0] ent_limit;
  logic             ent_valid;
  logic [2:0]       ent_perm;
  flt_e             flt_c;
  logic [PA_W-1:0]  pa_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (len_we_i) len_q <= (len_i > LEN_W'(NUM_SEG)) ? LEN_W'(NUM_SEG) : len_i;
  end

  seg_table #(
    .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .PA_W(PA_W), .LIM_W(LIM_W)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .widx_i   (tbl_idx_i),
    .wbase_i  (tbl_base_i),
    .wlimit_i (tbl_limit_i),
    .wvalid_i (tbl_valid_i),
    .wperm_i  (tbl_perm_i),
    .ridx_i   (seg_i[IDX_W-1:0]),
    .rbase_o  (ent_base),
    .rlimit_o (ent_limit),
    .rvalid_o (ent_valid),
    .rperm_o  (ent_perm)
  );

  seg_check #(
    .SNUM_W(SNUM_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_check (
    .seg_i   (seg_i),
    .len_i   (len_q),
    .off_i   (off_i),
    .acc_i   (acc_i),
    .base_i  (ent_base),
    .limit_i (ent_limit),
    .valid_i (ent_valid),
    .perm_i  (ent_perm),
    .flt_o   (flt_c),
    .pa_o    (pa_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      pa_o           <= '0;
      fault_o        <= '0;
      fault_strobe_o <= 1'b0;
    end else if (req_valid_i) begin
      rsp_valid_o    <= 1'b1;
      fault_o        <= flt_c;
      fault_strobe_o <= (flt_c != FLT_NONE);
      pa_o           <= (flt_c == FLT_NONE) ? pa_c : '0;
    end else begin
      rsp_valid_o    <= 1'b0;
      pa_o           <= '0;
      fault_o        <= '0;
      fault_strobe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned SNUM_W  = 4,
  parameter int unsigned PA_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [SNUM_W-1:0] seg_i,
  input logic              rsp_valid_o,
  input logic [PA_W-1:0]   pa_o,
  input logic [2:0]        fault_o,
  input logic              fault_strobe_o
);
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_strobe_o |-> (pa_o == '0)); // R8

  AST_STROBE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (fault_strobe_o == (fault_o != 3'd0))); // R8

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !fault_strobe_o && fault_o == 3'd0 && pa_o == '0)); // R12

  AST_SEG_BEYOND_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && seg_i >= SNUM_W'(NUM_SEG)) |=> (fault_o == 3'd1)); // R2
endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .NUM_SEG(NUM_SEG), .SNUM_W(SNUM_W), .PA_W(PA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .seg_i          (seg_i),
  .rsp_valid_o    (rsp_valid_o),
  .pa_o           (pa_o),
  .fault_o        (fault_o),
  .fault_strobe_o (fault_strobe_o)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  seg_i = '0;
  logic [11:0] off_i = '0;
  logic [1:0]  acc_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [2:0]  tbl_idx_i = '0;
  logic [15:0] tbl_base_i = '0;
  logic [12:0] tbl_limit_i = '0;
  logic        tbl_valid_i = 1'b0;
  logic [2:0]  tbl_perm_i = '0;
  logic        len_we_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic        rsp_valid_o;
  logic [15:0] pa_o;
  logic [2:0]  fault_o;
  logic        fault_strobe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  seg_xlate_unit u_dut (.*);

  // {seg, off, acc, fault, pa}
  localparam logic [36:0] VEC [14] = '{
    {4'd0,  12'h010, 2'd0, 3'd0, 16'h1010},
    {4'd0,  12'h0FF, 2'd2, 3'd0, 16'h10FF},
    {4'd0,  12'h100, 2'd0, 3'd3, 16'h0000},
    {4'd0,  12'h020, 2'd1, 3'd4, 16'h0000},
    {4'd1,  12'h03F, 2'd1, 3'd0, 16'h203F},
    {4'd1,  12'h010, 2'd2, 3'd4, 16'h0000},
    {4'd2,  12'h000, 2'd0, 3'd2, 16'h0000},
    {4'd4,  12'h000, 2'd0, 3'd1, 16'h0000},
    {4'd3,  12'h100, 2'd0, 3'd0, 16'h0080},
    {4'd1,  12'h050, 2'd2, 3'd3, 16'h0000},
    {4'd2,  12'hFFF, 2'd1, 3'd2, 16'h0000},
    {4'd15, 12'h000, 2'd0, 3'd1, 16'h0000},
    {4'd3,  12'h000, 2'd3, 3'd4, 16'h0000},
    {4'd3,  12'hFFF, 2'd1, 3'd0, 16'h0F7F}
  };

  task automatic chk_rsp(string tag, logic [2:0] ef, logic [15:0] ep);
    n_chk++;
    if (rsp_valid_o !== 1'b1 || fault_o !== ef || pa_o !== ep ||
        fault_strobe_o !== (ef != 3'd0)) begin
      n_err++;
      $display("FAIL %s: valid=%0b fault=%0d pa=%h strobe=%0b expected valid=1 fault=%0d pa=%h strobe=%0b",
               tag, rsp_valid_o, fault_o, pa_o, fault_strobe_o, ef, ep, ef != 3'd0);
    end
  endtask

  task automatic chk_idle(string tag);
    n_chk++;
    if (rsp_valid_o !== 1'b0 || fault_o !== 3'd0 || pa_o !== 16'h0 || fault_strobe_o !== 1'b0) begin
      n_err++;
      $display("FAIL %s: valid=%0b fault=%0d pa=%h strobe=%0b expected all zero",
               tag, rsp_valid_o, fault_o, pa_o, fault_strobe_o);
    end
  endtask

  // called at a negedge, returns at the next negedge with the response visible
  task automatic do_req(logic [3:0] s, logic [11:0] o, logic [1:0] a);
    req_valid_i = 1'b1; seg_i = s; off_i = o; acc_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wr_ent(logic [2:0] i, logic [15:0] b, logic [12:0] l, logic v, logic [2:0] p);
    tbl_we_i = 1'b1; tbl_idx_i = i; tbl_base_i = b; tbl_limit_i = l;
    tbl_valid_i = v; tbl_perm_i = p;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic wr_len(logic [3:0] n);
    len_we_i = 1'b1; len_i = n;
    @(negedge clk_i);
    len_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1 outputs in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 outputs after reset");
    do_req(4'd0, 12'h0, 2'd0);
    chk_rsp("R1 length zero after reset", 3'd1, 16'h0);
    wr_len(4'd8);
    do_req(4'd5, 12'h0, 2'd0);
    chk_rsp("R1 entries invalid after reset", 3'd2, 16'h0);

    wr_ent(3'd0, 16'h1000, 13'h0100, 1'b1, 3'b101);
    wr_ent(3'd1, 16'h2000, 13'h0040, 1'b1, 3'b011);
    wr_ent(3'd2, 16'h3000, 13'h0800, 1'b0, 3'b111);
    wr_ent(3'd3, 16'hFF80, 13'h1000, 1'b1, 3'b111);
    wr_len(4'd4);

    for (int k = 0; k < 14; k++) begin
      do_req(VEC[k][36:33], VEC[k][32:21], VEC[k][20:19]);
      chk_rsp($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8)", k), VEC[k][18:16], VEC[k][15:0]);
    end

    @(negedge clk_i);
    chk_idle("R12 no request");

    // length write and request in the same cycle
    len_we_i = 1'b1; len_i = 4'd2;
    do_req(4'd3, 12'h010, 2'd0);
    len_we_i = 1'b0;
    chk_rsp("R9 same-cycle request sees old length", 3'd0, 16'hFF90);
    do_req(4'd3, 12'h010, 2'd0);
    chk_rsp("R9 new length next cycle", 3'd1, 16'h0);

    wr_len(4'd15);
    do_req(4'd7, 12'h0, 2'd0);
    chk_rsp("R10 saturated length covers seg 7", 3'd2, 16'h0);
    do_req(4'd8, 12'h0, 2'd0);
    chk_rsp("R10 saturated length excludes seg 8", 3'd1, 16'h0);

    // table write and request in the same cycle
    tbl_we_i = 1'b1; tbl_idx_i = 3'd1; tbl_base_i = 16'h5000;
    tbl_limit_i = 13'h0040; tbl_valid_i = 1'b0; tbl_perm_i = 3'b111;
    do_req(4'd1, 12'h010, 2'd0);
    tbl_we_i = 1'b0;
    chk_rsp("R11 same-cycle request sees old entry", 3'd0, 16'h2010);
    do_req(4'd1, 12'h010, 2'd0);
    chk_rsp("R11 new entry next cycle", 3'd2, 16'h0);
    @(negedge clk_i);
    chk_idle("R12 idle after faults");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule